// File: doc/BRIEF.md
# Hash Compression Round Engine

This block performs the 64-round compression step of a 256-bit hash chaining state. It holds eight 32-bit working words, labelled A to H. A start pulse loads a 256-bit chaining value. The engine then runs exactly one round per clock. In each round it takes the plain expanded word and the paired (xor-combined) expanded word from an external expansion unit.

The engine reports which round it will execute next on `round_o`. The expansion unit uses that index to present the matching word pair in the same cycle. After the last round, the working words are XORed with the chaining value captured at start. The result becomes the new digest, and `done_o` pulses for one cycle.

The round logic has two phases. For the first sixteen rounds, both mixing functions are a three-way XOR. For the remaining rounds they switch to a majority form on the A side and a choose form on the E side. A per-round constant is rotated by the round index, and a permutation P0 is applied on the E path. Message padding and block streaming live outside this block.

Top module: `hcr_engine`

## Requirements
- R1: When `busy_o` is low, a cycle with `start_i` high loads `chain_i` as the working state and as the saved chaining value. In the next cycle, `busy_o` is high and `round_o` is 0. Word A is `chain_i[255:224]`, and the words follow down to H at `chain_i[31:0]`. `digest_o` uses the same word order.
- R2: While busy, each clock executes round `round_o` using `w_i` (the word W[j]) and `wp_i` (the word W'[j]) present in that cycle. `round_o` then increases by one.
- R3: For rounds 0 to 15, both FF and GG equal x xor y xor z.
- R4: For rounds 16 to 63, FF is (x and y) or (x and z) or (y and z), and GG is (x and y) or (not x and z).
- R5: The constant for round j is 0x79cc4519 for j below 16 and 0x7a879d8a otherwise, rotated left by j mod 32. For example, round 16 uses 0x9d8a7a87.
- R6: Each round computes SS1 = rol(rol(A,12)+E+T,7), SS2 = SS1 xor rol(A,12), TT1 = FF(A,B,C)+D+SS2+W' and TT2 = GG(E,F,G)+H+SS1+W, with all sums modulo 2^32. It then updates A=TT1, B=A, C=rol(B,9), D=C, E=P0(TT2), F=E, G=rol(F,19), H=G, where P0(x) = x xor rol(x,9) xor rol(x,17). While busy, `digest_o` shows the working words.
- R7: Round 63 writes each working word XORed with the matching saved chaining word into the state, and that value appears on `digest_o`.
- R8: `done_o` is high for exactly one cycle: the cycle after round 63 executes. In that same cycle, `busy_o` is low.
- R9: While idle and without a start, `digest_o` holds its value.
- R10: A `start_i` while `busy_o` is high is ignored. The round sequence and the working state continue unchanged.
- R11: After reset, `busy_o`, `done_o`, `round_o` and `digest_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load chaining value and begin compression |
| chain_i | input | 256 | Chaining value, A in the top word |
| w_i | input | 32 | Expanded word W[j] for round `round_o` |
| wp_i | input | 32 | Paired expanded word W'[j] for round `round_o` |
| round_o | output | 6 | Index of the round executed this cycle |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | One-cycle pulse when the digest is updated |
| digest_o | output | 256 | Working words while busy, digest when idle |

## Verification
The working words are visible on `digest_o` during every round, so a wrong round function, constant or rotation shows up at the ports one cycle after the faulty round. It does not stay hidden until the digest. A wrong switch point between the two function phases therefore appears at round 16 exactly. A feed-forward fault appears only in the cycle that `done_o` rises. Control faults, such as a restart on an ignored start or a missing or doubled done pulse, appear on `round_o`, `busy_o` and `done_o` in the following cycle.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned N_WORDS = 8;

   typedef logic [WORD_W-1:0] word_t;
   // index 7 is A, index 0 is H
   typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

   localparam int unsigned IDX_A = 7;
   localparam int unsigned IDX_B = 6;
   localparam int unsigned IDX_C = 5;
   localparam int unsigned IDX_D = 4;
   localparam int unsigned IDX_E = 3;
   localparam int unsigned IDX_F = 2;
   localparam int unsigned IDX_G = 1;
   localparam int unsigned IDX_H = 0;

   function automatic word_t rotl(input word_t x, input int unsigned n);
      int unsigned k;
      k = n % WORD_W;
      if (k == 0) return x;
      return (x << k) | (x >> (WORD_W - k));
   endfunction

   function automatic word_t perm0(input word_t x, input int unsigned r1, input int unsigned r2);
      return x ^ rotl(x, r1) ^ rotl(x, r2);
   endfunction
endpackage

// File: rtl/hcr_const_gen.sv
module hcr_const_gen
   import hcr_pkg::*;
#(
   parameter int unsigned ROUNDS       = 64,
   parameter int unsigned SWITCH_ROUND = 16,
   parameter logic [31:0] T_LOW        = 32'h79cc4519,
   parameter logic [31:0] T_HIGH       = 32'h7a879d8a,
   parameter bit          USE_TABLE    = 1'b1,
   localparam int unsigned RW          = $clog2(ROUNDS)
) (
   input  logic [RW-1:0] rnd_i,
   output word_t         tj_o
);
   if (USE_TABLE) begin : g_table
      word_t tbl [ROUNDS];
      for (genvar k = 0; k < ROUNDS; k++) begin : g_ent
         assign tbl[k] = rotl((k < SWITCH_ROUND) ? T_LOW : T_HIGH, k % WORD_W);
      end
      assign tj_o = tbl[rnd_i];
   end else begin : g_barrel
      logic [4:0]  sh;
      logic [63:0] dbl;
      word_t       base;
      assign base = (rnd_i >= RW'(SWITCH_ROUND)) ? T_HIGH : T_LOW;
      assign sh   = 5'(rnd_i);
      assign dbl  = {base, base};
      assign tj_o = dbl[(6'd63 - {1'b0, sh}) -: 32];
   end
endmodule

// File: rtl/hcr_round.sv
module hcr_round
   import hcr_pkg::*;
#(
   parameter int unsigned ROT_A  = 12,
   parameter int unsigned ROT_SS = 7,
   parameter int unsigned ROT_B  = 9,
   parameter int unsigned ROT_F  = 19,
   parameter int unsigned P0_R1  = 9,
   parameter int unsigned P0_R2  = 17
) (
   input  state_t cur_i,
   input  word_t  w_i,
   input  word_t  wp_i,
   input  word_t  tj_i,
   input  logic   hi_i,
   output state_t nxt_o
);
   word_t va, vb, vc, vd, ve, vf, vg, vh;
   word_t a_rot, ss1, ss2, ff, gg, tt1, tt2;

   assign va = cur_i[IDX_A];
   assign vb = cur_i[IDX_B];
   assign vc = cur_i[IDX_C];
   assign vd = cur_i[IDX_D];
   assign ve = cur_i[IDX_E];
   assign vf = cur_i[IDX_F];
   assign vg = cur_i[IDX_G];
   assign vh = cur_i[IDX_H];

   assign a_rot = rotl(va, ROT_A);
   assign ss1   = rotl(a_rot + ve + tj_i, ROT_SS);
   assign ss2   = ss1 ^ a_rot;

   always_comb begin
      if (hi_i) begin
         ff = (va & vb) | (va & vc) | (vb & vc);
         gg = (ve & vf) | (~ve & vg);
      end else begin
         ff = va ^ vb ^ vc;
         gg = ve ^ vf ^ vg;
      end
   end

   assign tt1 = ff + vd + ss2 + wp_i;
   assign tt2 = gg + vh + ss1 + w_i;

   always_comb begin
      nxt_o        = '0;
      nxt_o[IDX_A] = tt1;
      nxt_o[IDX_B] = va;
      nxt_o[IDX_C] = rotl(vb, ROT_B);
      nxt_o[IDX_D] = vc;
      nxt_o[IDX_E] = perm0(tt2, P0_R1, P0_R2);
      nxt_o[IDX_F] = ve;
      nxt_o[IDX_G] = rotl(vf, ROT_F);
      nxt_o[IDX_H] = vg;
   end
endmodule

// File: rtl/hcr_seq.sv
module hcr_seq #(
   parameter int unsigned ROUNDS = 64,
   localparam int unsigned RW    = $clog2(ROUNDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          load_o,
   output logic          last_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [RW-1:0] rnd_o
);
   assign load_o = start_i & ~busy_o;
   assign last_o = busy_o & (rnd_o == RW'(ROUNDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         rnd_o  <= '0;
      end else begin
         done_o <= last_o;
         if (load_o) begin
            busy_o <= 1'b1;
            rnd_o  <= '0;
         end else if (busy_o) begin
            if (last_o) begin
               busy_o <= 1'b0;
               rnd_o  <= '0;
            end else begin
               rnd_o <= rnd_o + 1'b1;
            end
         end
      end
   end

   a_r1_load_begins: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> busy_o && rnd_o == '0);
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> busy_o && rnd_o == $past(rnd_o) + 1'b1);
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> done_o && !busy_o);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/hcr_engine.sv
module hcr_engine
   import hcr_pkg::*;
#(
   parameter int unsigned ROUNDS       = 64,
   parameter int unsigned SWITCH_ROUND = 16,
   parameter logic [31:0] T_LOW        = 32'h79cc4519,
   parameter logic [31:0] T_HIGH       = 32'h7a879d8a,
   parameter bit          USE_TABLE    = 1'b1,
   localparam int unsigned RW          = $clog2(ROUNDS),
   localparam int unsigned SW          = WORD_W * N_WORDS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [SW-1:0] chain_i,
   input  logic [31:0]   w_i,
   input  logic [31:0]   wp_i,
   output logic [RW-1:0] round_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [SW-1:0] digest_o
);
   if (ROUNDS < 2 || SWITCH_ROUND >= ROUNDS) begin : g_bad_rounds
      $error("hcr_engine: SWITCH_ROUND must lie inside ROUNDS");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("hcr_engine: word width must be 32");
   end

   logic   load, last;
   state_t st_q, saved_q, nxt, fin;
   word_t  tj;

   hcr_seq #(.ROUNDS(ROUNDS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .load_o (load),
      .last_o (last),
      .busy_o (busy_o),
      .done_o (done_o),
      .rnd_o  (round_o)
   );

   hcr_const_gen #(
      .ROUNDS      (ROUNDS),
      .SWITCH_ROUND(SWITCH_ROUND),
      .T_LOW       (T_LOW),
      .T_HIGH      (T_HIGH),
      .USE_TABLE   (USE_TABLE)
   ) u_const (
      .rnd_i(round_o),
      .tj_o (tj)
   );

   hcr_round u_round (
      .cur_i(st_q),
      .w_i  (w_i),
      .wp_i (wp_i),
      .tj_i (tj),
      .hi_i (round_o >= RW'(SWITCH_ROUND)),
      .nxt_o(nxt)
   );

   for (genvar i = 0; i < N_WORDS; i++) begin : g_ffwd
      assign fin[i] = nxt[i] ^ saved_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         saved_q <= '0;
      end else if (load) begin
         st_q    <= state_t'(chain_i);
         saved_q <= state_t'(chain_i);
      end else if (busy_o) begin
         st_q <= last ? fin : nxt;
      end
   end

   assign digest_o = SW'(st_q);

   a_r9_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(digest_o));
   a_r1_chain_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> digest_o == $past(chain_i));
endmodule

// File: tb/tb_hcr_engine.sv
`timescale 1ns/1ps
module tb_hcr_engine;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [255:0] chain_i = '0;
   logic [31:0]  w_i = '0;
   logic [31:0]  wp_i = '0;
   logic [5:0]   round_o;
   logic         busy_o, done_o;
   logic [255:0] digest_o;

   always #4 clk = ~clk;   // 125 MHz

   hcr_engine dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_i(chain_i),
      .w_i(w_i), .wp_i(wp_i), .round_o(round_o), .busy_o(busy_o),
      .done_o(done_o), .digest_o(digest_o)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   // behavioural reference: m_r[0] is A ... m_r[7] is H
   logic [31:0] m_r [8];
   logic [31:0] m_sv [8];
   bit          m_busy, m_done, m_valid;
   int          m_round;
   logic [31:0] wexp [68];
   logic [31:0] blk [16];

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      logic [31:0] y;
      y = x;
      for (int i = 0; i < n; i++) y = {y[30:0], y[31]};
      return y;
   endfunction

   function automatic logic [255:0] pack_m();
      logic [255:0] p;
      for (int i = 0; i < 8; i++) p[255 - 32*i -: 32] = m_r[i];
      return p;
   endfunction

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // negedge: compare, then predict the coming edge from the stable inputs
   always @(negedge clk) begin
      logic [31:0] t, ss1, ss2, fv, gv, tt1, tt2, a12, p0;
      logic [31:0] o [8];
      cycles++;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_r[i] = '0; m_sv[i] = '0; end
         m_busy = 0; m_done = 0; m_round = 0; m_valid = 1;
      end else if (m_valid) begin
         chk("R2 busy_o", {255'd0, busy_o}, {255'd0, m_busy});
         chk("R2 round_o", {250'd0, round_o}, 256'(m_round));
         chk("R8 done_o", {255'd0, done_o}, {255'd0, m_done});
         chk(m_busy ? "R6 working state" : "R9 digest_o", digest_o, pack_m());
         m_done = 0;
         if (!m_busy && start_i) begin
            for (int i = 0; i < 8; i++) begin
               m_r[i] = chain_i[255 - 32*i -: 32]; m_sv[i] = m_r[i];
            end
            m_busy = 1; m_round = 0;
         end else if (m_busy) begin
            t   = rl((m_round < 16) ? 32'h79cc4519 : 32'h7a879d8a, m_round % 32);
            a12 = rl(m_r[0], 12);
            ss1 = rl(a12 + m_r[4] + t, 7);
            ss2 = ss1 ^ a12;
            if (m_round < 16) begin
               fv = m_r[0] ^ m_r[1] ^ m_r[2];
               gv = m_r[4] ^ m_r[5] ^ m_r[6];
            end else begin
               fv = (m_r[0] & m_r[1]) | (m_r[0] & m_r[2]) | (m_r[1] & m_r[2]);
               gv = (m_r[4] & m_r[5]) | (~m_r[4] & m_r[6]);
            end
            tt1 = fv + m_r[3] + ss2 + wp_i;
            tt2 = gv + m_r[7] + ss1 + w_i;
            p0  = tt2 ^ rl(tt2, 9) ^ rl(tt2, 17);
            o[0] = tt1; o[1] = m_r[0]; o[2] = rl(m_r[1], 9); o[3] = m_r[2];
            o[4] = p0;  o[5] = m_r[4]; o[6] = rl(m_r[5], 19); o[7] = m_r[6];
            for (int i = 0; i < 8; i++) m_r[i] = o[i];
            if (m_round == 63) begin
               for (int i = 0; i < 8; i++) m_r[i] = m_r[i] ^ m_sv[i];
               m_busy = 0; m_done = 1; m_round = 0;
            end else begin
               m_round++;
            end
         end
      end
      if (cycles > 100000 && !finished) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=<100000", cycles);
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic expand();
      logic [31:0] x;
      for (int j = 0; j < 16; j++) wexp[j] = blk[j];
      for (int j = 16; j < 68; j++) begin
         x = wexp[j-16] ^ wexp[j-9] ^ rl(wexp[j-3], 15);
         wexp[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(wexp[j-13], 7) ^ wexp[j-6];
      end
   endtask

   // drive one block; optional stray start at round 5 (R10)
   task automatic run_block(input logic [255:0] cv, input bit stray);
      @(posedge clk); #1;
      start_i = 1; chain_i = cv;
      @(posedge clk); #1;
      start_i = 0; chain_i = ~cv;
      for (int j = 0; j < 64; j++) begin
         w_i = wexp[j]; wp_i = wexp[j] ^ wexp[j+4];
         start_i = stray && (j == 5);
         @(posedge clk); #1;
         if (stray && j == 5) begin
            // R10: ignored start keeps the sequence going
            chk("R10 round after stray start", {250'd0, round_o}, 256'd6);
            chk("R10 busy after stray start", {255'd0, busy_o}, 256'd1);
         end
      end
      start_i = 0;
   endtask

   initial begin
      logic [255:0] iv;
      iv = 256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R11: reset values
      chk("R11 reset busy/done/round", {248'd0, busy_o, done_o, round_o}, 256'd0);
      chk("R11 reset digest", digest_o, 256'd0);

      // known block: exercises R3, R4, R5, R6 and R7 end to end
      for (int i = 0; i < 16; i++) blk[i] = '0;
      blk[0] = 32'h61626380; blk[15] = 32'h00000018;
      expand();
      run_block(iv, 1'b0);
      chk("R8 done after round 63", {255'd0, done_o}, 256'd1);
      chk("R7 known digest", digest_o,
          256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0);
      @(posedge clk); #1;
      chk("R8 done single cycle", {255'd0, done_o}, 256'd0);
      repeat (5) @(posedge clk);   // R9 idle hold checked every cycle
      #1;
      chk("R9 digest held idle", digest_o,
          256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0);

      // R1/R10: patterned block with a stray start while busy
      for (int i = 0; i < 16; i++) blk[i] = 32'h9e3779b9 * (i + 1) ^ 32'h0f0f1234;
      expand();
      run_block({8{32'hdeadbeef}} ^ iv, 1'b1);
      // back to back, all-ones chaining value, zero words
      for (int i = 0; i < 16; i++) blk[i] = '0;
      expand();
      run_block({256{1'b1}}, 1'b0);
      // chained from previous digest, alternating bits
      for (int i = 0; i < 16; i++) blk[i] = (i % 2) ? 32'h55555555 : 32'haaaaaaaa;
      expand();
      run_block(digest_o, 1'b0);
      repeat (4) @(posedge clk);
      #1;
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule